// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block maps processor physical addresses onto PCI bus addresses through four programmable outbound windows. Software programs each window through a 32-bit register port addressed by a 12-bit byte offset within the controller register page. Each window has a base address, a translation address, an extended translation word and an attribute word. The attribute word carries an enable bit and a size exponent.

A separate combinational lookup port takes a 64-bit processor address. It reports whether an enabled window covers that address, which window it is, and the PCI address the access would be sent to. A register write changes the mapping from the next clock cycle on. One spare 32-bit register in the page is read/write storage only.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every register reads zero and no lookup address produces a hit.
- R2: Window k (k = 1 to 4) occupies offsets 0xC00 + k*0x20 and up. Within a window, offset 0x00 is the translation register, 0x04 the extended translation register, 0x08 the base register and 0x10 the attribute register. A value written to one of these reads back unchanged at the same offset.
- R3: Any offset that is not one of the sixteen window registers and is not the spare register reads zero. Writes to such an offset change no register. This includes offsets inside a window's 0x20 span and offsets that are not word aligned.
- R4: The register at offset 0xE20 reads back the last value written to it and has no effect on any lookup result.
- R5: A window whose attribute bit 31 is 0 never produces a hit, whatever its other registers hold.
- R6: An enabled window covers byte addresses from B to B + S - 1, where B is the base register shifted left by 12 and S is 2 shifted left by attribute bits [5:0]. Comparisons are exact at both edges, including sizes up to 2^64.
- R7: On a hit, the PCI address is (translation register shifted left by 12) + (address - B), taken modulo 2^64. The extended translation register does not affect it.
- R8: When several enabled windows cover an address, the window with the lowest index is reported. The index output gives the window number 1 to 4.
- R9: On a miss, the hit flag, the index output and the PCI address output are all zero.
- R10: A write to any window register takes effect on lookups in the cycle after the write edge. Lookup results change only after a register write or a change of the lookup address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regOff | input | 12 | Register byte offset for reads and writes |
| regWe | input | 1 | Write strobe for the register at regOff |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regOff |
| lkAddr | input | 64 | Processor address to translate |
| lkHit | output | 1 | An enabled window covers lkAddr |
| lkIdx | output | 3 | Number of the winning window, 1 to 4, or 0 on a miss |
| lkPciAddr | output | 64 | Translated PCI address, or 0 on a miss |

## Verification
The assertions expect reset to be held for at least one clock edge, so that the register state is defined before checking starts. They also expect regOff and regWrData to be stable across the edge on which a write is sampled. The spare-register read-back property and the lookup-stability property depend on this. The bench drives every input on the falling edge and holds it for a whole cycle. It pulses reset for several edges before any access, and it changes the lookup address only between checks, so the stimulus stays within these assumptions.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  parameter int unsigned WIN_COUNT = 4;

  typedef enum logic [2:0] {
    FLD_NONE  = 3'd0,
    FLD_XLAT  = 3'd1,
    FLD_XEXT  = 3'd2,
    FLD_BASE  = 3'd3,
    FLD_ATTR  = 3'd4,
    FLD_SPARE = 3'd5
  } fieldSel_e;

  typedef struct packed {
    logic                 wrStb;
    logic [WIN_COUNT-1:0] winOneHot;
    fieldSel_e            field;
  } regCmd_t;

endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl #(
  parameter int unsigned OFF_W = 12,
  parameter logic [OFF_W-1:0] OUT_PAGE  = 12'hC00,
  parameter logic [OFF_W-1:0] SPARE_OFF = 12'hE20
) (
  input  logic [OFF_W-1:0]   regOff,
  input  logic               regWe,
  output obwin_pkg::regCmd_t cmd
);
  import obwin_pkg::*;

  localparam int unsigned SLOT_W = 3;

  logic [SLOT_W-1:0] slot;
  logic              inPage;
  logic              slotOk;
  fieldSel_e         winField;

  assign slot   = regOff[7:5];
  assign inPage = (regOff[OFF_W-1:8] == OUT_PAGE[OFF_W-1:8]);
  assign slotOk = inPage && (32'(slot) >= 32'd1) && (32'(slot) <= WIN_COUNT);

  always_comb begin
    case (regOff[4:0])
      5'h00:   winField = FLD_XLAT;
      5'h04:   winField = FLD_XEXT;
      5'h08:   winField = FLD_BASE;
      5'h10:   winField = FLD_ATTR;
      default: winField = FLD_NONE;
    endcase
  end

  always_comb begin
    cmd.wrStb     = regWe;
    cmd.winOneHot = '0;
    cmd.field     = FLD_NONE;
    if (regOff == SPARE_OFF) begin
      cmd.field = FLD_SPARE;
    end else if (slotOk && (winField != FLD_NONE)) begin
      cmd.field = winField;
      for (int i = 0; i < int'(WIN_COUNT); i++) begin
        cmd.winOneHot[i] = (slot == SLOT_W'(i + 1));
      end
    end
  end

endmodule

// File: rtl/obwin_match.sv
module obwin_match #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GRAN_SH = 12,
  parameter int unsigned EXP_W   = 6
) (
  input  logic              winEn,
  input  logic [EXP_W-1:0]  sizeExp,
  input  logic [DATA_W-1:0] baseReg,
  input  logic [DATA_W-1:0] xlatReg,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              hit,
  output logic [ADDR_W-1:0] pciAddr
);

  localparam int unsigned PAD_W = ADDR_W - DATA_W - GRAN_SH;

  logic [ADDR_W-1:0] baseByte;
  logic [ADDR_W-1:0] xlatByte;
  logic [ADDR_W:0]   winSize;
  logic [ADDR_W:0]   winLimit;
  logic [ADDR_W-1:0] offsetIn;

  assign baseByte = {{PAD_W{1'b0}}, baseReg, {GRAN_SH{1'b0}}};
  assign xlatByte = {{PAD_W{1'b0}}, xlatReg, {GRAN_SH{1'b0}}};
  assign winSize  = (ADDR_W + 1)'(2) << sizeExp;
  assign winLimit = {1'b0, baseByte} + winSize;
  assign offsetIn = lkAddr - baseByte;

  assign hit     = winEn && (lkAddr >= baseByte) && ({1'b0, lkAddr} < winLimit);
  assign pciAddr = xlatByte + offsetIn;

endmodule

// File: rtl/obwin_dpath.sv
module obwin_dpath #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GRAN_SH = 12,
  parameter int unsigned EXP_W   = 6,
  parameter int unsigned EN_BIT  = 31,
  parameter int unsigned IDX_W   = $clog2(obwin_pkg::WIN_COUNT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  obwin_pkg::regCmd_t cmd,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic               lkHit,
  output logic [IDX_W-1:0]   lkIdx,
  output logic [ADDR_W-1:0]  lkPciAddr
);
  import obwin_pkg::*;

  localparam int unsigned NW = WIN_COUNT;

  logic [DATA_W-1:0] xlatReg [NW];
  logic [DATA_W-1:0] xextReg [NW];
  logic [DATA_W-1:0] baseReg [NW];
  logic [DATA_W-1:0] attrReg [NW];
  logic [DATA_W-1:0] spareReg;

  logic [NW-1:0]     hitVec;
  logic [ADDR_W-1:0] pciVec [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      spareReg <= '0;
      for (int i = 0; i < int'(NW); i++) begin
        xlatReg[i] <= '0;
        xextReg[i] <= '0;
        baseReg[i] <= '0;
        attrReg[i] <= '0;
      end
    end else if (cmd.wrStb) begin
      if (cmd.field == FLD_SPARE) spareReg <= wrData;
      for (int i = 0; i < int'(NW); i++) begin
        if (cmd.winOneHot[i]) begin
          case (cmd.field)
            FLD_XLAT: xlatReg[i] <= wrData;
            FLD_XEXT: xextReg[i] <= wrData;
            FLD_BASE: baseReg[i] <= wrData;
            FLD_ATTR: attrReg[i] <= wrData;
            default:  ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (cmd.field == FLD_SPARE) rdData = spareReg;
    for (int i = 0; i < int'(NW); i++) begin
      if (cmd.winOneHot[i]) begin
        case (cmd.field)
          FLD_XLAT: rdData = xlatReg[i];
          FLD_XEXT: rdData = xextReg[i];
          FLD_BASE: rdData = baseReg[i];
          FLD_ATTR: rdData = attrReg[i];
          default:  ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < int'(NW); g++) begin : g_win
    obwin_match #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .GRAN_SH(GRAN_SH),
      .EXP_W  (EXP_W)
    ) u_match (
      .winEn  (attrReg[g][EN_BIT]),
      .sizeExp(attrReg[g][EXP_W-1:0]),
      .baseReg(baseReg[g]),
      .xlatReg(xlatReg[g]),
      .lkAddr (lkAddr),
      .hit    (hitVec[g]),
      .pciAddr(pciVec[g])
    );
  end

  always_comb begin
    lkHit     = 1'b0;
    lkIdx     = '0;
    lkPciAddr = '0;
    for (int i = int'(NW) - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        lkHit     = 1'b1;
        lkIdx     = IDX_W'(i + 1);
        lkPciAddr = pciVec[i];
      end
    end
  end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate #(
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GRAN_SH = 12,
  parameter int unsigned EXP_W   = 6,
  parameter int unsigned EN_BIT  = 31,
  parameter int unsigned IDX_W   = $clog2(obwin_pkg::WIN_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  regOff,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPciAddr
);

  obwin_pkg::regCmd_t cmd;

  obwin_ctrl #(
    .OFF_W(OFF_W)
  ) u_ctrl (
    .regOff(regOff),
    .regWe (regWe),
    .cmd   (cmd)
  );

  obwin_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GRAN_SH(GRAN_SH),
    .EXP_W  (EXP_W),
    .EN_BIT (EN_BIT),
    .IDX_W  (IDX_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .lkAddr   (lkAddr),
    .lkHit    (lkHit),
    .lkIdx    (lkIdx),
    .lkPciAddr(lkPciAddr)
  );

endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk #(
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [OFF_W-1:0]  regOff,
  input logic              regWe,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic [IDX_W-1:0]  lkIdx,
  input logic [ADDR_W-1:0] lkPciAddr
);

  localparam logic [OFF_W-1:0] SPARE_AT = 12'hE20;

  logic pageHole;
  assign pageHole = (regOff[OFF_W-1:8] == 4'hC) &&
                    (regOff[4:0] != 5'h00) && (regOff[4:0] != 5'h04) &&
                    (regOff[4:0] != 5'h08) && (regOff[4:0] != 5'h10);

  // R1: first cycle out of reset shows cleared state
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lkHit && regRdData == '0));

  // R3: holes in the window page read zero
  p_hole_zero_r3: assert property (@(posedge clk) disable iff (rst)
    pageHole |-> (regRdData == '0));

  // R4: spare register holds the written word
  p_spare_store_r4: assert property (@(posedge clk) disable iff (rst)
    (regWe && regOff == SPARE_AT) |=>
      ((regOff != SPARE_AT) || (regRdData == $past(regWrData))));

  // R8: the reported window number stays in range on a hit
  p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> (lkIdx >= 3'd1 && lkIdx <= 3'(obwin_pkg::WIN_COUNT)));

  // R9: a miss drives all lookup outputs to zero
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> (lkIdx == '0 && lkPciAddr == '0));

  // R10: no write and no address change keeps the lookup result still
  p_lookup_still_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(regWe) && $stable(lkAddr)) |->
      ($stable(lkHit) && $stable(lkIdx) && $stable(lkPciAddr)));

endmodule

bind obwin_xlate obwin_xlate_chk u_chk (.*);

// File: tb/obwin_xlate_tb.sv
`timescale 1ns/1ps
module obwin_xlate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] regOff = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] lkAddr = '0;
  logic        lkHit;
  logic [2:0]  lkIdx;
  logic [63:0] lkPciAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mX [1:4];
  logic [31:0] mE [1:4];
  logic [31:0] mB [1:4];
  logic [31:0] mA [1:4];
  logic [31:0] mSpare;

  always #2.5 clk = ~clk;

  obwin_xlate u_dut (
    .clk(clk), .rst(rst), .regOff(regOff), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkPciAddr(lkPciAddr)
  );

  function automatic int slotOf(input logic [11:0] o);
    if (o[11:8] == 4'hC && o[7:5] >= 3'd1 && o[7:5] <= 3'd4) return int'(o[7:5]);
    return 0;
  endfunction

  function automatic logic [31:0] mRead(input logic [11:0] o);
    int s = slotOf(o);
    if (o == 12'hE20) return mSpare;
    if (s != 0) begin
      case (o[4:0])
        5'h00: return mX[s];
        5'h04: return mE[s];
        5'h08: return mB[s];
        5'h10: return mA[s];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  function automatic void mWrite(input logic [11:0] o, input logic [31:0] d);
    int s = slotOf(o);
    if (o == 12'hE20) mSpare = d;
    if (s != 0) begin
      case (o[4:0])
        5'h00: mX[s] = d;
        5'h04: mE[s] = d;
        5'h08: mB[s] = d;
        5'h10: mA[s] = d;
        default: ;
      endcase
    end
  endfunction

  task automatic mLookup(input logic [63:0] a, output logic h,
                         output logic [2:0] ix, output logic [63:0] pa);
    h = 1'b0; ix = 3'd0; pa = 64'd0;
    for (int k = 4; k >= 1; k--) begin
      logic [63:0] b;
      logic [64:0] sz;
      b  = {20'b0, mB[k], 12'b0};
      sz = 65'd2 << mA[k][5:0];
      if (mA[k][31] && a >= b && {1'b0, a} < ({1'b0, b} + sz)) begin
        h = 1'b1; ix = 3'(k);
        pa = {20'b0, mX[k], 12'b0} + (a - b);
      end
    end
  endtask

  task automatic wrReg(input logic [11:0] o, input logic [31:0] d);
    @(negedge clk);
    regOff = o; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    mWrite(o, d);
  endtask

  task automatic chkRead(input logic [11:0] o, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    regOff = o;
    #1;
    exp = mRead(o);
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s read off=%h actual=%h expected=%h", tag, o, regRdData, exp);
    end
  endtask

  task automatic chkLook(input logic [63:0] a, input string tag);
    logic h; logic [2:0] ix; logic [63:0] pa;
    @(negedge clk);
    lkAddr = a;
    #1;
    mLookup(a, h, ix, pa);
    checks++;
    if (lkHit !== h || lkIdx !== ix || lkPciAddr !== pa) begin
      fails++;
      $display("FAIL %s lookup a=%h actual=%b/%0d/%h expected=%b/%0d/%h",
               tag, a, lkHit, lkIdx, lkPciAddr, h, ix, pa);
    end
  endtask

  task automatic clearWins();
    for (int k = 1; k <= 4; k++) begin
      wrReg(12'(12'hC00 + k * 32 + 'h00), 32'h0);
      wrReg(12'(12'hC00 + k * 32 + 'h04), 32'h0);
      wrReg(12'(12'hC00 + k * 32 + 'h08), 32'h0);
      wrReg(12'(12'hC00 + k * 32 + 'h10), 32'h0);
    end
  endtask

  function automatic logic [11:0] wOff(input int k, input int f);
    return 12'(12'hC00 + k * 32 + f);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= 4; k++) begin mX[k] = 0; mE[k] = 0; mB[k] = 0; mA[k] = 0; end
    mSpare = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: cleared registers, no hit anywhere
    for (int o = 'hC00; o < 'hE40; o += 4) chkRead(12'(o), "R1");
    chkLook(64'h0, "R1");
    chkLook(64'hFFFF_FFFF_FFFF_FFFF, "R1");
    chkLook(64'h0000_0001_0000_0000, "R1");

    // R2 R3 R4: write a pattern everywhere, including unaligned offsets
    for (int o = 'hBE0; o < 'hE60; o += 4)
      wrReg(12'(o), 32'h5A00_0000 ^ (32'(o) * 32'h0001_0101));
    wrReg(12'hC21, 32'hDEAD_BEEF);
    wrReg(12'hC4A, 32'hCAFE_F00D);
    wrReg(12'hE22, 32'h1234_5678);
    for (int o = 'hBE0; o < 'hE60; o += 4)
      chkRead(12'(o), (slotOf(12'(o)) != 0 && mRead(12'(o)) != 0) ? "R2" :
                      (o == 'hE20) ? "R4" : "R3");
    chkRead(12'hC21, "R3");
    chkRead(12'hC20, "R3");
    chkRead(12'hE22, "R3");

    clearWins();

    // R6 R7: size and edge sweep for every window and exponent
    for (int k = 1; k <= 4; k++) begin
      for (int n = 0; n < 64; n++) begin
        logic [63:0] b;
        logic [64:0] sz;
        wrReg(wOff(k, 'h08), 32'h0010_0000 * 32'(k));
        wrReg(wOff(k, 'h00), 32'h0ABC_0000 ^ 32'(k * 7 + n));
        wrReg(wOff(k, 'h10), 32'h8000_0000 | 32'(n));
        b  = {20'b0, mB[k], 12'b0};
        sz = 65'd2 << n;
        chkLook(b - 64'd1, "R6");
        chkLook(b, "R7");
        chkLook(64'(({1'b0, b} + sz) - 65'd1), "R7");
        chkLook(64'({1'b0, b} + sz), "R6");
      end
      wrReg(wOff(k, 'h10), 32'h0);
    end

    // R5: enable bit gates the window
    wrReg(wOff(2, 'h08), 32'h0000_3000);
    wrReg(wOff(2, 'h00), 32'h0007_7000);
    wrReg(wOff(2, 'h10), 32'h8000_0014);
    chkLook(64'h0000_0000_0300_0123, "R5");
    wrReg(wOff(2, 'h10), 32'h7FFF_FF14);
    chkLook(64'h0000_0000_0300_0123, "R5");
    chkLook(64'h0000_0000_0300_0000, "R5");

    // R8: overlapping windows, lowest number wins
    for (int k = 1; k <= 4; k++) begin
      wrReg(wOff(k, 'h08), 32'h0004_0000);
      wrReg(wOff(k, 'h00), 32'h0100_0000 * 32'(k));
      wrReg(wOff(k, 'h10), 32'h8000_0010 + 32'(k));
    end
    chkLook(64'h0000_0000_4000_0040, "R8");
    for (int k = 1; k <= 3; k++) begin
      // R10: the disable is visible on the very next lookup
      wrReg(wOff(k, 'h10), 32'h0);
      chkLook(64'h0000_0000_4000_0040, "R10");
      chkLook(64'h0000_0000_4002_0000, "R8");
    end

    // R7: extended translation register has no effect
    wrReg(wOff(4, 'h04), 32'hFFFF_FFFF);
    chkLook(64'h0000_0000_4000_1234, "R7");

    // R4: spare register does not disturb lookups
    wrReg(12'hE20, 32'h8000_003F);
    chkLook(64'h0000_0000_4000_1234, "R4");
    chkRead(12'hE20, "R4");

    // R9: miss outputs are zero
    chkLook(64'h0000_0000_3FFF_FFFF, "R9");
    chkLook(64'h8000_0000_0000_0000, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule